// File: doc/BRIEF.md
# Serialized Interrupt Host Controller

This block is the host end of a single shared, pulled-up interrupt wire. It frames interrupt packets on that wire, gives every interrupt source a one-clock sample slot inside the packet, and turns what it sees in those slots into a parallel vector of requested interrupt lines. The host only ever pulls the wire low or drives it high for one clock. Devices pull low in their own slot to request service.

A packet starts with a long low pulse from the host. A two-clock turnaround follows, then one slot per source spaced three clocks apart. The packet closes with a short low stop pulse and a second turnaround. The length of the stop pulse selects the mode for the next packet. With a three-clock stop the host keeps starting packets on its own after a fixed idle gap. With a two-clock stop the host waits until a device pulls the wire low for one clock, then extends that pulse to a full start pulse. The slot count is a parameter. Its default of 17 covers sixteen ordinary interrupts plus a non-maskable one in the last slot.

Top module: `irq_serial_host`

## Requirements
- R1: The host never drives the wire low and high in the same clock. It drives high only in the clock directly after one of its own low pulses. In every other clock it either pulls low or releases the wire.
- R2: In continuous mode the start pulse lasts `start_len_i` clocks. `start_len_i` is an unsigned count, and values below 4 are treated as 4 and values above 8 as 8.
- R3: After the start pulse the host drives high for exactly one clock and then releases the wire for one clock. The clock after that is the sample clock of slot 0.
- R4: Counting the high turnaround clock as clock 0, slot k is sampled in clock 3k+2. A low wire in that clock sets bit k of `irq_o`, and a high wire clears it. Bit NUM_SLOTS-1 is the last slot, which by default carries the non-maskable request.
- R5: `irq_o` changes only as a whole. The update happens at the end of a packet, in the same clock in which `frame_done_o` pulses high for exactly one clock. Between packets `irq_o` holds its value.
- R6: The stop pulse starts after the two turnaround clocks that follow the last slot. It lasts 2 clocks when `quiet_req_i` is 1 and 3 clocks when it is 0. One high clock and one released clock follow it. `quiet_mode_o` takes the value of `quiet_req_i` together with `frame_done_o` (1 = quiet, 0 = continuous).
- R7: In continuous mode exactly `gap_i`+3 clocks without host low drive separate the end of a stop pulse from the next start pulse. A one-clock low from a device during that gap neither starts nor shifts the next packet.
- R8: In quiet mode the host never starts a packet by itself. When a device holds the wire low for one clock while the host is idle, the host drives low for the following 7 clocks, so the start pulse is 8 clocks long in total.
- R9: During reset `irq_o` is all zero, `frame_done_o` is low, the wire is released and the mode is continuous.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_i | input | 1 | Sampled level of the shared pulled-up wire |
| start_len_i | input | 4 | Continuous-mode start pulse length in clocks (clamped to 4..8) |
| gap_i | input | GAP_W | Continuous-mode idle gap control |
| quiet_req_i | input | 1 | Select quiet mode (short stop) for the next packet |
| drive_low_o | output | 1 | Host pulls the wire low |
| drive_high_o | output | 1 | Host actively drives the wire high |
| irq_o | output | NUM_SLOTS | Requested interrupt vector, bit k = slot k |
| frame_done_o | output | 1 | One-clock pulse when `irq_o` is updated |
| quiet_mode_o | output | 1 | Current mode, 1 = quiet |

## Verification
The bench builds the block with the default 17 slots and an 8-bit gap control. This brings the last slot (bit 16, the non-maskable request) and the first slot within reach of single-bit and all-ones patterns. Gap values of 6 and 20 leave room to inject a stray device pulse in the middle of a continuous idle gap. Start-length inputs of 2, 4, 8 and 12 reach both clamp limits. A device model follows the packet from the host's drive pins alone and answers in its slots. It checks pulse lengths, turnaround and gap timing across continuous-to-quiet and quiet-to-continuous switches.

// File: rtl/irqser_pkg.sv
package irqser_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_TA_HI, ST_TA_REL, ST_SLOT, ST_STOP, ST_END_HI, ST_END_REL
  } phase_e;

  localparam int unsigned START_MIN  = 4;
  localparam int unsigned START_MAX  = 8;
  localparam int unsigned QUIET_LEN  = 8;
  localparam int unsigned STOP_CONT  = 3;
  localparam int unsigned STOP_QUIET = 2;
  localparam int unsigned SLOT_PITCH = 3;

  function automatic logic [3:0] clamp_start(input logic [3:0] v);
    if (v < 4'(START_MIN)) return 4'(START_MIN);
    else if (v > 4'(START_MAX)) return 4'(START_MAX);
    else return v;
  endfunction
endpackage

// File: rtl/irqser_seq.sv
module irqser_seq
  import irqser_pkg::*;
#(
  parameter int NS    = 17,
  parameter int GAP_W = 8,
  localparam int SW   = (NS > 1) ? $clog2(NS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_i,
  input  logic [3:0]       start_len_i,
  input  logic [GAP_W-1:0] gap_i,
  input  logic             quiet_req_i,
  output logic             drive_low_o,
  output logic             drive_high_o,
  output logic             sample_o,
  output logic [SW-1:0]    slot_o,
  output logic             end_o,
  output logic             quiet_o,
  output logic             idle_o
);
  localparam logic [SW-1:0] LAST_SLOT = SW'(NS - 1);
  localparam logic [1:0]    LAST_PH   = 2'(SLOT_PITCH - 1);

  phase_e           st_q, st_d;
  logic [3:0]       cnt_q, cnt_d, tgt_q, tgt_d;
  logic [SW-1:0]    slot_q, slot_d;
  logic [1:0]       ph_q, ph_d;
  logic [GAP_W-1:0] gap_q, gap_d;
  logic             quiet_q, quiet_d, stopq_q, stopq_d;

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    tgt_d   = tgt_q;
    slot_d  = slot_q;
    ph_d    = ph_q;
    gap_d   = gap_q;
    quiet_d = quiet_q;
    stopq_d = stopq_q;
    unique case (st_q)
      ST_IDLE: begin
        if (quiet_q) begin
          if (!line_i) begin
            st_d  = ST_START;
            cnt_d = 4'd1;
            tgt_d = 4'(QUIET_LEN);
          end
        end else if (gap_q >= gap_i) begin
          st_d  = ST_START;
          cnt_d = 4'd0;
          tgt_d = clamp_start(start_len_i);
        end else begin
          gap_d = gap_q + 1'b1;
        end
      end
      ST_START: begin
        cnt_d = cnt_q + 4'd1;
        if (cnt_q + 4'd1 == tgt_q) st_d = ST_TA_HI;
      end
      ST_TA_HI:  st_d = ST_TA_REL;
      ST_TA_REL: begin
        st_d   = ST_SLOT;
        slot_d = '0;
        ph_d   = 2'd0;
      end
      ST_SLOT: begin
        if (ph_q == LAST_PH) begin
          if (slot_q == LAST_SLOT) begin
            st_d    = ST_STOP;
            cnt_d   = 4'd0;
            tgt_d   = quiet_req_i ? 4'(STOP_QUIET) : 4'(STOP_CONT);
            stopq_d = quiet_req_i;
          end else begin
            slot_d = slot_q + 1'b1;
            ph_d   = 2'd0;
          end
        end else begin
          ph_d = ph_q + 2'd1;
        end
      end
      ST_STOP: begin
        cnt_d = cnt_q + 4'd1;
        if (cnt_q + 4'd1 == tgt_q) st_d = ST_END_HI;
      end
      ST_END_HI:  st_d = ST_END_REL;
      ST_END_REL: begin
        st_d    = ST_IDLE;
        gap_d   = '0;
        quiet_d = stopq_q;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      tgt_q   <= '0;
      slot_q  <= '0;
      ph_q    <= '0;
      gap_q   <= '0;
      quiet_q <= 1'b0;
      stopq_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      cnt_q   <= cnt_d;
      tgt_q   <= tgt_d;
      slot_q  <= slot_d;
      ph_q    <= ph_d;
      gap_q   <= gap_d;
      quiet_q <= quiet_d;
      stopq_q <= stopq_d;
    end
  end

  assign drive_low_o  = (st_q == ST_START) || (st_q == ST_STOP);
  assign drive_high_o = (st_q == ST_TA_HI) || (st_q == ST_END_HI);
  assign sample_o     = (st_q == ST_SLOT) && (ph_q == 2'd0);
  assign slot_o       = slot_q;
  assign end_o        = (st_q == ST_END_REL);
  assign quiet_o      = quiet_q;
  assign idle_o       = (st_q == ST_IDLE);
endmodule

// File: rtl/irqser_capture.sv
module irqser_capture #(
  parameter int NS = 17,
  parameter int SW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          line_i,
  input  logic          sample_i,
  input  logic [SW-1:0] slot_i,
  input  logic          end_i,
  output logic [NS-1:0] irq_o,
  output logic          done_o
);
  logic [NS-1:0] shadow_q;

  for (genvar k = 0; k < NS; k++) begin : g_slot
    logic hit;
    assign hit = sample_i && (slot_i == SW'(k));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   shadow_q[k] <= 1'b0;
      else if (hit) shadow_q[k] <= ~line_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_o  <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= end_i;
      if (end_i) irq_o <= shadow_q;
    end
  end
endmodule

// File: rtl/irq_serial_host.sv
module irq_serial_host #(
  parameter int NUM_SLOTS = 17,
  parameter int GAP_W     = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 line_i,
  input  logic [3:0]           start_len_i,
  input  logic [GAP_W-1:0]     gap_i,
  input  logic                 quiet_req_i,
  output logic                 drive_low_o,
  output logic                 drive_high_o,
  output logic [NUM_SLOTS-1:0] irq_o,
  output logic                 frame_done_o,
  output logic                 quiet_mode_o
);
  localparam int SW = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;

  logic          sample_w, end_w, idle_w;
  logic [SW-1:0] slot_w;

  irqser_seq #(.NS(NUM_SLOTS), .GAP_W(GAP_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .line_i(line_i), .start_len_i(start_len_i),
    .gap_i(gap_i), .quiet_req_i(quiet_req_i), .drive_low_o(drive_low_o),
    .drive_high_o(drive_high_o), .sample_o(sample_w), .slot_o(slot_w),
    .end_o(end_w), .quiet_o(quiet_mode_o), .idle_o(idle_w)
  );

  irqser_capture #(.NS(NUM_SLOTS), .SW(SW)) u_cap (
    .clk(clk), .rst_n(rst_n), .line_i(line_i), .sample_i(sample_w),
    .slot_i(slot_w), .end_i(end_w), .irq_o(irq_o), .done_o(frame_done_o)
  );
endmodule

// File: rtl/irqser_chk.sv
module irqser_chk #(
  parameter int NS = 17
) (
  input logic          clk,
  input logic          rst_n,
  input logic          line_i,
  input logic          drive_low_i,
  input logic          drive_high_i,
  input logic          done_i,
  input logic          quiet_i,
  input logic          idle_i,
  input logic [NS-1:0] irq_i
);
  assert_low_high_excl_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(drive_low_i && drive_high_i));

  assert_high_after_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
    drive_high_i |-> $past(drive_low_i));

  assert_high_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    drive_high_i |=> !drive_high_i);

  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_i |=> !done_i);

  assert_vec_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !done_i |-> $stable(irq_i));

  assert_mode_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !done_i |-> $stable(quiet_i));

  assert_quiet_wait_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet_i && idle_i && line_i) |=> !drive_low_i);
endmodule

bind irq_serial_host irqser_chk #(.NS(NUM_SLOTS)) u_chk (
  .clk(clk), .rst_n(rst_n), .line_i(line_i), .drive_low_i(drive_low_o),
  .drive_high_i(drive_high_o), .done_i(frame_done_o), .quiet_i(quiet_mode_o),
  .idle_i(idle_w), .irq_i(irq_o)
);

// File: tb/sim_irq_serial_host.sv
module sim_irq_serial_host;
  localparam int NS = 17;
  localparam int GW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [3:0]    start_len = 4'd4;
  logic [GW-1:0] gap = 8'd6;
  logic          quiet_req = 1'b0;
  logic          drive_low, drive_high, frame_done, quiet_mode;
  logic [NS-1:0] irq;
  logic          slot_pull = 1'b0, start_pull = 1'b0;
  logic          line;
  logic [NS-1:0] pend = '0;
  logic [NS-1:0] expv[$];
  logic          expm[$];
  int checks = 0, errors = 0;

  assign line = ~(drive_low | slot_pull | start_pull);

  irq_serial_host #(.NUM_SLOTS(NS), .GAP_W(GW)) u0 (
    .clk(clk), .rst_n(rst_n), .line_i(line), .start_len_i(start_len),
    .gap_i(gap), .quiet_req_i(quiet_req), .drive_low_o(drive_low),
    .drive_high_o(drive_high), .irq_o(irq), .frame_done_o(frame_done),
    .quiet_mode_o(quiet_mode)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int clampv(input int v);
    return (v < 4) ? 4 : ((v > 8) ? 8 : v);
  endfunction

  // device model: follows the host's drive pins and answers in its slots
  initial begin : dev_model
    int run, idle_cnt, last_stop, t, stop_run, er, es;
    bit in_frame;
    run = 0; idle_cnt = 0; last_stop = 0; t = 0; stop_run = 0; in_frame = 0;
    forever begin
      @(negedge clk);
      if (!rst_n) continue;
      if (!in_frame) begin
        slot_pull = 1'b0;
        if (drive_low) begin
          if (run == 0 && last_stop == 3)
            chk(idle_cnt == int'(gap) + 3, "R7", "clocks between packets", idle_cnt, int'(gap) + 3);
          run++;
        end else begin
          if (run >= 4) begin
            er = (last_stop == 2) ? 7 : clampv(int'(start_len));
            chk(run == er, (last_stop == 2) ? "R8" : "R2", "start pulse length", run, er);
            chk(drive_high == 1'b1, "R3", "first turnaround high", drive_high, 1);
            in_frame = 1; t = 0; stop_run = 0; idle_cnt = 0;
          end else begin
            idle_cnt++;
          end
          run = 0;
        end
      end else begin
        if (drive_low) begin
          stop_run++;
          slot_pull = 1'b0;
        end else if (stop_run > 0) begin
          es = quiet_req ? 2 : 3;
          chk(stop_run == es, "R6", "stop pulse length", stop_run, es);
          chk(drive_high == 1'b1, "R6", "stop turnaround high", drive_high, 1);
          last_stop = stop_run; in_frame = 0; idle_cnt = 1;
        end else begin
          t++;
          if (t == 1) chk(drive_high == 1'b0, "R3", "second turnaround released", drive_high, 0);
          if (t >= 2 && (t - 2) % 3 == 0 && (t - 2) / 3 < NS) slot_pull = pend[(t - 2) / 3];
          else slot_pull = 1'b0;
        end
      end
    end
  end

  // monitor: scoreboard compare on every completed packet
  initial begin : monitor
    logic [NS-1:0] ev;
    logic em;
    forever begin
      @(negedge clk);
      if (rst_n && frame_done) begin
        if (expv.size() == 0) chk(1'b0, "R5", "unexpected packet end", 1, 0);
        else begin
          ev = expv.pop_front();
          em = expm.pop_front();
          chk(irq == ev, "R4", "irq vector", irq, ev);
          chk(quiet_mode == em, "R6", "mode after packet", quiet_mode, em);
        end
      end
    end
  end

  task automatic run_frame(input logic [NS-1:0] v, input bit qreq, input logic [3:0] sl,
                           input bit qstart, input bit noise);
    pend = v; quiet_req = qreq; start_len = sl;
    expv.push_back(v);
    expm.push_back(qreq);
    if (qstart) begin
      repeat (3) @(negedge clk);
      start_pull = 1'b1;
      @(negedge clk);
      start_pull = 1'b0;
    end
    if (noise) begin
      repeat (5) @(negedge clk);
      start_pull = 1'b1;
      @(negedge clk);
      start_pull = 1'b0;
    end
    do @(negedge clk); while (!frame_done);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    chk(1'b0, "WD", "watchdog expired", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    int lows;
    logic [NS-1:0] held;
    repeat (3) @(negedge clk);
    chk(irq == '0, "R9", "reset vector", irq, 0);
    chk(!drive_low && !drive_high, "R9", "reset wire released", {drive_low, drive_high}, 0);
    chk(!quiet_mode, "R9", "reset mode continuous", quiet_mode, 0);
    chk(!frame_done, "R9", "reset done low", frame_done, 0);
    rst_n = 1'b1;

    run_frame(17'h10001, 1'b0, 4'd4, 1'b0, 1'b0);   // R4 first and last slot
    run_frame(17'h00000, 1'b0, 4'd8, 1'b0, 1'b0);   // R2 max start
    run_frame(17'h1FFFF, 1'b0, 4'd2, 1'b0, 1'b0);   // R2 clamp low, all slots
    run_frame(17'h0A5A5, 1'b1, 4'd12, 1'b0, 1'b0);  // R2 clamp high, R6 into quiet

    // R8: quiet mode, host stays silent; R5 vector holds
    lows = 0;
    held = irq;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (drive_low || frame_done) lows++;
    end
    chk(lows == 0, "R8", "no host start in quiet idle", lows, 0);
    chk(irq == held, "R5", "vector held between packets", irq, held);

    run_frame(17'h00040, 1'b1, 4'd4, 1'b1, 1'b0);   // R8 device-started packet
    run_frame(17'h08000, 1'b0, 4'd5, 1'b1, 1'b0);   // back to continuous
    gap = 8'd20;
    run_frame(17'h1FFFE, 1'b0, 4'd6, 1'b0, 1'b1);   // R7 stray pulse ignored
    run_frame(17'h00100, 1'b0, 4'd4, 1'b0, 1'b0);   // R7 gap timing
    chk(expv.size() == 0, "R5", "all packets reported", expv.size(), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule